// File: doc/BRIEF.md
# Mapped Nonvolatile Byte Array Write Controller

This block holds a small byte-addressed nonvolatile array that sits inside the data address space. A read on the mapped bus returns the committed byte at once, with no wait. A mapped write lands in a page buffer. What then happens to the array depends on the command last accepted into a protected command register. In write-only mode the stored byte can only lose set bits. In erase-and-write mode the byte is replaced. In any other mode the write is held in the buffer, marked as pending, and the array does not change.

The command register is written over a byte register bus. A write there is accepted only while the unlock input from an external key-window block is high. An erase command sets every byte back to the erased value. Two further commands drop all pending buffer marks. A write mode stays selected for any number of mapped writes. The pending state of the buffer can be seen on a single output.

Top module: `eepromWriteTop`

## Requirements
- R1: After reset every mapped byte reads 0xFF, the command register reads 0x00 and `pendingAny` is 0.
- R2: A command write is accepted only when `cmdWrEn` and `unlock` are both high at the clock edge. Without `unlock` the write is dropped and `cmdRdData` keeps its value.
- R3: With command 0x12 selected, a mapped write sets the addressed byte to its old value AND the written data.
- R4: With command 0x13 selected, a mapped write replaces the addressed byte with the written data.
- R5: Command 0x12 or 0x13 stays selected across any number of mapped writes. After command 0x00 or 0x01 is accepted, mapped writes no longer change the array.
- R6: A mapped write made while the command is neither 0x12 nor 0x13 leaves the array unchanged and raises `pendingAny`.
- R7: Accepting command 0x00 or 0x01 clears every pending mark, so `pendingAny` is 0 on the next cycle. A mapped write committed under 0x12 or 0x13 leaves no pending mark for its byte.
- R8: Accepting command 0x18 sets every byte to 0xFF and clears all pending marks. It takes precedence over a mapped write in the same cycle, which is then lost.
- R9: Any accepted code is stored and read back on `cmdRdData`. A code other than 0x12 or 0x13 turns mapped writes into buffer-only writes. Codes 0x00, 0x01 and 0x18 also have the actions given above.
- R10: The window is addresses 0x1400 to 0x14FF, and byte i sits at 0x1400+i. Reads return the array byte combinationally in the same cycle. Outside the window a read returns 0x00 and a write has no effect.
- R11: When a command write and a mapped write share a clock edge, the mapped write is committed under the command held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 8 | Command code to write |
| cmdRdData | output | 8 | Current command register value |
| unlock | input | 1 | Key window open; gates command writes |
| memAddr | input | 16 | Mapped bus address |
| memWrData | input | 8 | Mapped bus write data |
| memWrEn | input | 1 | Mapped bus write strobe |
| memRdData | output | 8 | Mapped bus read data (combinational) |
| pendingAny | output | 1 | At least one buffered byte is marked pending |

## Verification
A command update and a mapped data write can land on the same clock edge. In that case the data write must follow the mode in force before the edge, and an erase in that cycle must win over the write. The bench provokes this on purpose in two cases. In the first, erase-and-write mode is selected in the same cycle as a write made from idle mode: the byte must stay 0xFF and the write must be left pending. In the second, an erase arrives together with a replace-mode write: the byte must read 0xFF afterwards. Random sequences also overlap the two buses often. Every outcome is judged against a bench model that applies the old command first and the new command after.

// File: rtl/eepromPkg.sv
package eepromPkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_IDLE     = 8'h00;
  localparam logic [CMD_W-1:0] CMD_NOP      = 8'h01;
  localparam logic [CMD_W-1:0] CMD_AND_WR   = 8'h12;
  localparam logic [CMD_W-1:0] CMD_REPL_WR  = 8'h13;
  localparam logic [CMD_W-1:0] CMD_ERASE    = 8'h18;

  // strobes issued by control for one clock edge
  typedef struct packed {
    logic bufWrite;   // accepted mapped write (buffer side)
    logic commitAnd;  // merge write data into array with AND
    logic commitRepl; // overwrite array byte
    logic eraseAll;   // whole array to erased value
    logic dropDirty;  // clear every pending mark
  } eeStrobe_t;
endpackage

// File: rtl/eeCtrl.sv
module eeCtrl
  import eepromPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MAP_BASE = 'h1400,
  parameter int DEPTH    = 256,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic              unlock,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrEn,
  output logic [CMD_W-1:0]  cmdReg,
  output logic              inWindow,
  output logic [IDX_W-1:0]  idx,
  output eeStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(MAP_BASE);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(DEPTH);

  logic [ADDR_W-1:0] offset;
  logic cmdAccept;
  logic mapWrite;
  logic modeAnd;
  logic modeRepl;

  assign offset    = memAddr - WIN_LO;
  assign inWindow  = (memAddr >= WIN_LO) && (offset < WIN_SIZE);
  assign idx       = offset[IDX_W-1:0];
  assign cmdAccept = cmdWrEn && unlock;

  always_ff @(posedge clk) begin
    if (!rstN)          cmdReg <= CMD_IDLE;
    else if (cmdAccept) cmdReg <= cmdWrData;
  end

  // mapped writes decode against the mode held before this edge
  assign modeAnd  = (cmdReg == CMD_AND_WR);
  assign modeRepl = (cmdReg == CMD_REPL_WR);

  always_comb begin
    strobe.eraseAll  = cmdAccept && (cmdWrData == CMD_ERASE);
    strobe.dropDirty = cmdAccept && ((cmdWrData == CMD_IDLE) || (cmdWrData == CMD_NOP));
    mapWrite         = memWrEn && inWindow && !strobe.eraseAll;
    strobe.bufWrite  = mapWrite;
    strobe.commitAnd = mapWrite && modeAnd;
    strobe.commitRepl = mapWrite && modeRepl;
  end
endmodule

// File: rtl/eeDatapath.sv
module eeDatapath
  import eepromPkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inWindow,
  output logic [DATA_W-1:0] rdData,
  output logic              pendingAny
);
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] cellArr [DEPTH];
  logic [DEPTH-1:0]  dirtyVec;

  for (genvar i = 0; i < DEPTH; i++) begin : gByte
    logic              hit;
    logic [DATA_W-1:0] cellQ;
    logic              dirtyQ;

    assign hit = (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN)                           cellQ <= ERASED;
      else if (strobe.eraseAll)            cellQ <= ERASED;
      else if (strobe.commitAnd && hit)    cellQ <= cellQ & wrData;
      else if (strobe.commitRepl && hit)   cellQ <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                    dirtyQ <= 1'b0;
      else if (strobe.eraseAll || strobe.dropDirty) dirtyQ <= 1'b0;
      else if (strobe.bufWrite && hit)
        dirtyQ <= !(strobe.commitAnd || strobe.commitRepl);
    end

    assign cellArr[i]  = cellQ;
    assign dirtyVec[i] = dirtyQ;
  end

  assign rdData     = inWindow ? cellArr[idx] : '0;
  assign pendingAny = |dirtyVec;
endmodule

// File: rtl/eepromWriteTop.sv
module eepromWriteTop
  import eepromPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MAP_BASE = 'h1400,
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  output logic [CMD_W-1:0]  cmdRdData,
  input  logic              unlock,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWrData,
  input  logic              memWrEn,
  output logic [DATA_W-1:0] memRdData,
  output logic              pendingAny
);
  localparam int IDX_W = $clog2(DEPTH);

  eeStrobe_t        strobe;
  logic             inWindow;
  logic [IDX_W-1:0] idx;

  eeCtrl #(
    .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .unlock(unlock), .memAddr(memAddr), .memWrEn(memWrEn),
    .cmdReg(cmdRdData), .inWindow(inWindow), .idx(idx), .strobe(strobe)
  );

  eeDatapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .wrData(memWrData),
    .inWindow(inWindow), .rdData(memRdData), .pendingAny(pendingAny)
  );
endmodule

// File: rtl/eepromChecker.sv
module eepromChecker #(
  parameter int ADDR_W   = 16,
  parameter int MAP_BASE = 'h1400,
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic [7:0]        cmdWrData,
  input logic [7:0]        cmdRdData,
  input logic              unlock,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memRdData,
  input logic              pendingAny
);
  logic inWin;
  logic accept;
  logic eraseAcc;
  logic clearAcc;

  assign inWin    = (int'(memAddr) >= MAP_BASE) && (int'(memAddr) < MAP_BASE + DEPTH);
  assign accept   = cmdWrEn && unlock;
  assign eraseAcc = accept && (cmdWrData == 8'h18);
  assign clearAcc = accept && ((cmdWrData == 8'h00) || (cmdWrData == 8'h01));

  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(cmdRdData));

  a_r9_code_stored: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> cmdRdData == $past(cmdWrData));

  a_r8_erase_clears: assert property (@(posedge clk) disable iff (!rstN)
    eraseAcc |=> !pendingAny);

  a_r7_clear_pending: assert property (@(posedge clk) disable iff (!rstN)
    clearAcc |=> !pendingAny);

  a_r6_idle_marks: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && inWin && cmdRdData != 8'h12 && cmdRdData != 8'h13 && !eraseAcc && !clearAcc)
      |=> pendingAny);

  a_r4_replace: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && inWin && cmdRdData == 8'h13 && !eraseAcc)
      |=> (memAddr != $past(memAddr)) || (memRdData == $past(memWrData)));

  a_r3_and_merge: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && inWin && cmdRdData == 8'h12 && !eraseAcc)
      |=> (memAddr != $past(memAddr)) || (memRdData == ($past(memRdData) & $past(memWrData))));

  a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |-> memRdData == '0);
endmodule

bind eepromWriteTop eepromChecker #(
  .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE), .DEPTH(DEPTH), .DATA_W(DATA_W)
) uChecker (.*);

// File: tb/tb_eepromWriteTop.sv
module tb_eepromWriteTop;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdWrEn;
  logic [7:0]  cmdWrData;
  logic [7:0]  cmdRdData;
  logic        unlock;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic        memWrEn;
  logic [7:0]  memRdData;
  logic        pendingAny;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [7:0] mArr [256];
  bit         mDirty [256];
  logic [7:0] mCmd;

  always #5 clk = ~clk;

  eepromWriteTop dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .unlock(unlock), .memAddr(memAddr),
    .memWrData(memWrData), .memWrEn(memWrEn), .memRdData(memRdData),
    .pendingAny(pendingAny)
  );

  function automatic bit inWin(input logic [15:0] a);
    return (a >= 16'h1400) && (a <= 16'h14FF);
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    return inWin(a) ? mArr[a[7:0]] : 8'h00;
  endfunction

  function automatic bit expPending();
    bit p = 1'b0;
    for (int i = 0; i < 256; i++) p |= mDirty[i];
    return p;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model of one edge: mapped write under the old command, then command update
  task automatic applyModel(input bit ce, input logic [7:0] cd, input bit ul,
                            input bit we, input logic [15:0] a, input logic [7:0] wd);
    bit acc = ce && ul;
    bit er  = acc && (cd == 8'h18);
    bit clr = acc && (cd == 8'h00 || cd == 8'h01);
    if (er) begin
      for (int i = 0; i < 256; i++) begin mArr[i] = 8'hFF; mDirty[i] = 1'b0; end
    end else begin
      if (we && inWin(a)) begin
        if (mCmd == 8'h12)      mArr[a[7:0]] = mArr[a[7:0]] & wd;
        else if (mCmd == 8'h13) mArr[a[7:0]] = wd;
        mDirty[a[7:0]] = !(mCmd == 8'h12 || mCmd == 8'h13);
      end
      if (clr) for (int i = 0; i < 256; i++) mDirty[i] = 1'b0;
    end
    if (acc) mCmd = cd;
  endtask

  task automatic step(input bit ce, input logic [7:0] cd, input bit ul,
                      input bit we, input logic [15:0] a, input logic [7:0] wd);
    @(negedge clk);
    cmdWrEn = ce; cmdWrData = cd; unlock = ul;
    memWrEn = we; memAddr = a; memWrData = wd;
    @(posedge clk);
    applyModel(ce, cd, ul, we, a, wd);
    #1;
    cmdWrEn = 1'b0; memWrEn = 1'b0; unlock = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    step(1'b1, c, 1'b1, 1'b0, 16'h0000, 8'h00);
  endtask

  task automatic mwr(input logic [15:0] a, input logic [7:0] d);
    step(1'b0, 8'h00, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    memAddr = a;
    #1;
    chk(tag, {8'h00, memRdData}, {8'h00, exp});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cmdWrEn = 1'b0; cmdWrData = 8'h00; unlock = 1'b0;
    memAddr = 16'h0000; memWrData = 8'h00; memWrEn = 1'b0;
    for (int i = 0; i < 256; i++) begin mArr[i] = 8'hFF; mDirty[i] = 1'b0; end
    mCmd = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 cmd", {8'h00, cmdRdData}, 16'h0000);
    chk("R1 pending", {15'h0, pendingAny}, 16'h0000);
    rd("R1 first byte", 16'h1400, 8'hFF);
    rd("R1 last byte", 16'h14FF, 8'hFF);

    // R10 outside window reads zero
    rd("R10 below window", 16'h13FF, 8'h00);
    rd("R10 above window", 16'h1500, 8'h00);

    // R2 locked command write dropped
    step(1'b1, 8'h13, 1'b0, 1'b0, 16'h0, 8'h0);
    @(negedge clk);
    chk("R2 locked drop", {8'h00, cmdRdData}, 16'h0000);

    // R6 idle write buffered only
    mwr(16'h1405, 8'h00);
    rd("R6 array unchanged", 16'h1405, 8'hFF);
    chk("R6 pending", {15'h0, pendingAny}, 16'h0001);

    // R7 noop clears pending
    cmd(8'h01);
    @(negedge clk);
    chk("R7 pending cleared", {15'h0, pendingAny}, 16'h0000);
    chk("R9 noop stored", {8'h00, cmdRdData}, 16'h0001);

    // R4 replace, R5 persistence
    cmd(8'h13);
    mwr(16'h1405, 8'hA5);
    rd("R4 replace", 16'h1405, 8'hA5);
    mwr(16'h1406, 8'h5A);
    rd("R5 second replace", 16'h1406, 8'h5A);
    chk("R7 committed not pending", {15'h0, pendingAny}, 16'h0000);

    // R3 AND merge
    cmd(8'h12);
    mwr(16'h1405, 8'h3C);
    rd("R3 and merge", 16'h1405, 8'h24);
    mwr(16'h1405, 8'hFF);
    rd("R3 cannot set bits", 16'h1405, 8'h24);
    mwr(16'h1406, 8'h0F);
    rd("R5 and persists", 16'h1406, 8'h0A);

    // R5 idle ends write mode
    cmd(8'h00);
    mwr(16'h1406, 8'h00);
    rd("R5 after idle", 16'h1406, 8'h0A);
    chk("R6 pending again", {15'h0, pendingAny}, 16'h0001);

    // R10 writes outside window ignored
    cmd(8'h13);
    mwr(16'h1500, 8'h00);
    mwr(16'h13FF, 8'h00);
    rd("R10 no alias low", 16'h1400, 8'hFF);
    rd("R10 no alias high", 16'h14FF, 8'hFF);

    // R9 unknown code stored, acts as buffer only
    cmd(8'h55);
    @(negedge clk);
    chk("R9 unknown stored", {8'h00, cmdRdData}, 16'h0055);
    mwr(16'h1407, 8'h00);
    rd("R9 unknown no commit", 16'h1407, 8'hFF);

    // R11 command and write share an edge: old mode governs
    cmd(8'h00);
    step(1'b1, 8'h13, 1'b1, 1'b1, 16'h1410, 8'h00);
    rd("R11 old idle mode", 16'h1410, 8'hFF);
    chk("R11 left pending", {15'h0, pendingAny}, 16'h0001);
    chk("R11 new cmd", {8'h00, cmdRdData}, 16'h0013);
    mwr(16'h1410, 8'h3C);
    rd("R11 new mode after", 16'h1410, 8'h3C);

    // R8 erase wins over same-cycle replace write
    step(1'b1, 8'h18, 1'b1, 1'b1, 16'h1405, 8'h11);
    rd("R8 erase beats write", 16'h1405, 8'hFF);
    rd("R8 erased other", 16'h1410, 8'hFF);
    chk("R8 pending cleared", {15'h0, pendingAny}, 16'h0000);
    chk("R9 erase stored", {8'h00, cmdRdData}, 16'h0018);

    // random mix checked against the model
    for (int n = 0; n < 1500; n++) begin
      logic [7:0]  cd;
      logic [15:0] a;
      logic [15:0] ra;
      int k = $urandom % 16;
      case (k)
        0:       cd = 8'h18;
        1, 2:    cd = 8'h00;
        3:       cd = 8'h01;
        4, 5, 6: cd = 8'h12;
        7, 8, 9: cd = 8'h13;
        default: cd = 8'($urandom);
      endcase
      if ($urandom % 10 == 0)     a = 16'($urandom);
      else if ($urandom % 2 == 0) a = 16'h1400 + 16'($urandom % 8);
      else                        a = 16'h1400 + 16'($urandom % 256);
      step(($urandom % 4) == 0, cd, ($urandom % 4) != 0, ($urandom % 2) == 0,
           a, 8'($urandom));
      ra = ($urandom % 2 == 0) ? a : 16'h1400 + 16'($urandom % 8);
      rd("R3 R4 R10 random read", ra, expRead(ra));
      chk("R6 R7 random pending", {15'h0, pendingAny}, {15'h0, expPending()});
      chk("R2 R9 random cmd", {8'h00, cmdRdData}, {8'h00, mCmd});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule